// File: doc/BRIEF.md
# Microcoded Instruction-Fetch Sequencer

This block drives the instruction-fetch steps of a simple processor datapath from stored control words rather than from gate logic. A small constant control store holds three 10-bit words, one for each fetch step. A micro-address register points at the next word to read. Each clock, a micro-buffer register captures the addressed word. The bits of that buffer are the ten datapath control lines.

A level-sensitive `start` input allows a new fetch to begin each time the sequencer is at address 0. Once a fetch has begun, it always runs through all three words. While the word that requests a memory read is on the outputs and `mem_ready` is low, the sequencer holds the read step unchanged.

Top module: `useq_top`

## Requirements
- R1: All ten control outputs come straight from the micro-buffer register. They change only on a rising clock edge.
- R2: While `rst` is high at a rising edge, the micro-address returns to 0 and every control output is 0 after that edge. This holds whatever `start` and `mem_ready` are doing.
- R3: Control-word bit positions are fixed. The mapping, from bit 9 down to bit 0, is: `pc_to_b1`, `one_to_b2`, `mbr_to_b2`, `alu_pass1`, `alu_add`, `alu_pass2`, `b3_to_pc`, `b3_to_ir`, `b3_to_mar`, `mem_read`.
- R4: The first fetch word is 10'b10010_00011. It asserts exactly `pc_to_b1`, `alu_pass1`, `b3_to_mar` and `mem_read`.
- R5: The second fetch word is 10'b11001_01000. It asserts exactly `pc_to_b1`, `one_to_b2`, `alu_add` and `b3_to_pc`. It follows the first word on the edge where `mem_read` is shown and `mem_ready` is high.
- R6: The third fetch word is 10'b00100_10100. It asserts exactly `mbr_to_b2`, `alu_pass2` and `b3_to_ir`. It always follows the second word on the next edge.
- R7: While `mem_read` is shown and `mem_ready` is low, the outputs and the micro-address hold at each edge. `mem_ready` has no effect while the second or third word is shown, or while the block is idle.
- R8: After the third word the micro-address wraps to 0. If `start` is high at that edge, the first word appears on the next edge with no idle cycle.
- R9: At micro-address 0 with `start` low, the buffer loads all zeros, so no control line is asserted and the block stays idle.
- R10: A fetch that has begun completes all three words even if `start` falls during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Allows a fetch to begin at micro-address 0 |
| mem_ready | input | 1 | Memory has completed the pending read |
| pc_to_b1 | output | 1 | Drive program counter onto source bus 1 |
| one_to_b2 | output | 1 | Drive constant one onto source bus 2 |
| mbr_to_b2 | output | 1 | Drive memory buffer onto source bus 2 |
| alu_pass1 | output | 1 | ALU passes bus 1 to result bus |
| alu_add | output | 1 | ALU adds bus 1 and bus 2 onto result bus |
| alu_pass2 | output | 1 | ALU passes bus 2 to result bus |
| b3_to_pc | output | 1 | Load program counter from result bus |
| b3_to_ir | output | 1 | Load instruction register from result bus |
| b3_to_mar | output | 1 | Load memory address register from result bus |
| mem_read | output | 1 | Request a memory read |

## Verification
Two decisions can fall on the same edge.

The first is the wrap from the third word back to address 0 together with the `start` decision. The bench holds `start` high across the third word and expects the read word on the very next edge. It then drops `start` at the same point and expects all-zero outputs.

The second is the read stall together with memory completion. The bench varies where `mem_ready` rises: on the first cycle of the read, after several low cycles, and while a non-read word is shown. A scoreboard compares every cycle's full 10-bit output against the word the requirements call for.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int CTL_W     = 10;
  localparam int FETCH_LEN = 3;

  typedef logic [CTL_W-1:0] ctl_word_t;

  // Bit positions of each control line inside a stored word.
  localparam int B_PC_B1   = 9;
  localparam int B_ONE_B2  = 8;
  localparam int B_MBR_B2  = 7;
  localparam int B_PASS1   = 6;
  localparam int B_ADD     = 5;
  localparam int B_PASS2   = 4;
  localparam int B_LD_PC   = 3;
  localparam int B_LD_IR   = 2;
  localparam int B_LD_MAR  = 1;
  localparam int B_READ    = 0;

  // Builds the fetch microprogram from the bit table above.
  function automatic ctl_word_t fetch_word(input int idx);
    ctl_word_t w;
    w = '0;
    case (idx)
      0: begin
        w[B_PC_B1]  = 1'b1;
        w[B_PASS1]  = 1'b1;
        w[B_LD_MAR] = 1'b1;
        w[B_READ]   = 1'b1;
      end
      1: begin
        w[B_PC_B1]  = 1'b1;
        w[B_ONE_B2] = 1'b1;
        w[B_ADD]    = 1'b1;
        w[B_LD_PC]  = 1'b1;
      end
      2: begin
        w[B_MBR_B2] = 1'b1;
        w[B_PASS2]  = 1'b1;
        w[B_LD_IR]  = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int AW    = 2,
  parameter int WORDS = 3
) (
  input  logic [AW-1:0] addr,
  output ctl_word_t     word
);

  localparam int DEPTH = 1 << AW;

  ctl_word_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    if (i < WORDS) begin : g_used
      assign rom[i] = fetch_word(i);
    end else begin : g_spare
      assign rom[i] = '0;
    end
  end

  assign word = rom[addr];

endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW    = 2,
  parameter int WORDS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stall,
  output logic [AW-1:0] uaddr,
  output logic          fill
);

  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic at_head;

  assign at_head = (uaddr == '0);
  assign fill    = !at_head || start;

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr <= '0;
    end else if (!stall && fill) begin
      uaddr <= (uaddr == LAST) ? '0 : uaddr + AW'(1);
    end
  end

endmodule

// File: rtl/useq_buf.sv
module useq_buf
  import useq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hold,
  input  logic      fill,
  input  ctl_word_t word_in,
  output ctl_word_t word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (!hold) begin
      word_q <= fill ? word_in : '0;
    end
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int WORDS = FETCH_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mem_ready,
  output logic pc_to_b1,
  output logic one_to_b2,
  output logic mbr_to_b2,
  output logic alu_pass1,
  output logic alu_add,
  output logic alu_pass2,
  output logic b3_to_pc,
  output logic b3_to_ir,
  output logic b3_to_mar,
  output logic mem_read
);

  localparam int AW = (WORDS > 2) ? $clog2(WORDS) : 1;

  logic [AW-1:0] uaddr;
  logic          fill;
  logic          stall;
  ctl_word_t     rom_word;
  ctl_word_t     ubuf_q;

  assign stall = ubuf_q[B_READ] && !mem_ready;

  useq_next #(.AW(AW), .WORDS(WORDS)) u_next (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .stall (stall),
    .uaddr (uaddr),
    .fill  (fill)
  );

  useq_store #(.AW(AW), .WORDS(WORDS)) u_store (
    .addr (uaddr),
    .word (rom_word)
  );

  useq_buf u_buf (
    .clk     (clk),
    .rst     (rst),
    .hold    (stall),
    .fill    (fill),
    .word_in (rom_word),
    .word_q  (ubuf_q)
  );

  assign pc_to_b1  = ubuf_q[B_PC_B1];
  assign one_to_b2 = ubuf_q[B_ONE_B2];
  assign mbr_to_b2 = ubuf_q[B_MBR_B2];
  assign alu_pass1 = ubuf_q[B_PASS1];
  assign alu_add   = ubuf_q[B_ADD];
  assign alu_pass2 = ubuf_q[B_PASS2];
  assign b3_to_pc  = ubuf_q[B_LD_PC];
  assign b3_to_ir  = ubuf_q[B_LD_IR];
  assign b3_to_mar = ubuf_q[B_LD_MAR];
  assign mem_read  = ubuf_q[B_READ];

endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      start,
  input logic      mem_ready,
  input ctl_word_t ctl
);

  localparam ctl_word_t W0 = fetch_word(0);
  localparam ctl_word_t W1 = fetch_word(1);
  localparam ctl_word_t W2 = fetch_word(2);

  a_r2_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl == '0));

  a_r7_read_hold: assert property (@(posedge clk) disable iff (rst)
    (ctl[B_READ] && !mem_ready) |=> $stable(ctl));

  a_r5_read_done: assert property (@(posedge clk) disable iff (rst)
    (ctl == W0 && mem_ready) |=> (ctl == W1));

  a_r6_incr_then_load: assert property (@(posedge clk) disable iff (rst)
    (ctl == W1) |=> (ctl == W2));

  a_r8_relaunch: assert property (@(posedge clk) disable iff (rst)
    (ctl == W2 && start) |=> (ctl == W0));

  a_r9_go_idle: assert property (@(posedge clk) disable iff (rst)
    ((ctl == W2 || ctl == '0) && !start) |=> (ctl == '0));

  a_r3_legal_word: assert property (@(posedge clk) disable iff (rst)
    (ctl == '0) || (ctl == W0) || (ctl == W1) || (ctl == W2));

endmodule

bind useq_top useq_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mem_ready (mem_ready),
  .ctl       (ubuf_q)
);

// File: tb/useq_top_tb.sv
module useq_top_tb;

  // Expected words, bit 9 first: pc_to_b1 one_to_b2 mbr_to_b2 alu_pass1
  // alu_add alu_pass2 b3_to_pc b3_to_ir b3_to_mar mem_read
  localparam logic [9:0] Z  = 10'b00000_00000;
  localparam logic [9:0] W0 = 10'b10010_00011;
  localparam logic [9:0] W1 = 10'b11001_01000;
  localparam logic [9:0] W2 = 10'b00100_10100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mem_ready = 1'b0;
  logic pc_to_b1, one_to_b2, mbr_to_b2, alu_pass1, alu_add;
  logic alu_pass2, b3_to_pc, b3_to_ir, b3_to_mar, mem_read;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [9:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  useq_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_ready (mem_ready),
    .pc_to_b1  (pc_to_b1),
    .one_to_b2 (one_to_b2),
    .mbr_to_b2 (mbr_to_b2),
    .alu_pass1 (alu_pass1),
    .alu_add   (alu_add),
    .alu_pass2 (alu_pass2),
    .b3_to_pc  (b3_to_pc),
    .b3_to_ir  (b3_to_ir),
    .b3_to_mar (b3_to_mar),
    .mem_read  (mem_read)
  );

  // Driver: set inputs for the next edge and queue the word due after it.
  task automatic step(input logic r, input logic s, input logic rdy,
                      input logic [9:0] exp, input string tag);
    @(negedge clk);
    rst = r;
    start = s;
    mem_ready = rdy;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [9:0] act;
        logic [9:0] exp;
        string      tag;
        act = {pc_to_b1, one_to_b2, mbr_to_b2, alu_pass1, alu_add,
               alu_pass2, b3_to_pc, b3_to_ir, b3_to_mar, mem_read};
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        checks++;
        if (act !== exp) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
      end
    end
  end

  initial begin
    // R2: reset clears outputs regardless of start and ready
    step(1, 1, 1, Z, "R2 reset");
    step(1, 1, 1, Z, "R2 reset");
    step(1, 1, 0, Z, "R2 reset");
    // R9: idle while start low
    step(0, 0, 1, Z, "R9 idle");
    step(0, 0, 0, Z, "R9 idle");
    // R4 R5 R6 R3: zero-wait fetch
    step(0, 1, 1, W0, "R4 word0");
    step(0, 1, 1, W1, "R5 word1");
    step(0, 0, 1, W2, "R6 word2");
    step(0, 0, 1, Z,  "R9 idle after wrap");
    // R7: stalled read
    step(0, 1, 0, W0, "R4 word0");
    step(0, 1, 0, W0, "R7 hold");
    step(0, 1, 0, W0, "R7 hold");
    step(0, 1, 1, W1, "R5 after ready");
    step(0, 1, 1, W2, "R6 word2");
    // R8: back-to-back fetch
    step(0, 1, 1, W0, "R8 relaunch");
    // R10: start drops mid-fetch
    step(0, 0, 1, W1, "R10 continue");
    step(0, 0, 1, W2, "R10 continue");
    step(0, 0, 1, Z,  "R9 idle");
    // R7: ready ignored off the read word
    step(0, 1, 0, W0, "R7 launch ready low");
    step(0, 1, 0, W0, "R7 hold");
    step(0, 1, 1, W1, "R5 word1");
    step(0, 1, 0, W2, "R7 ready ignored");
    step(0, 0, 0, Z,  "R9 idle");
    step(0, 0, 0, Z,  "R7 ready ignored idle");
    // R2 R1: reset in mid-fetch
    step(0, 1, 1, W0, "R4 word0");
    step(0, 1, 1, W1, "R5 word1");
    step(1, 1, 1, Z,  "R2 reset mid-fetch");
    step(0, 0, 1, Z,  "R2 address back to 0");
    step(0, 1, 1, W0, "R2 restart at word0");
    step(0, 0, 1, W1, "R1 word1");
    step(0, 0, 1, W2, "R1 word2");
    step(0, 0, 1, Z,  "R9 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule